// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block sits between a PWM command and the two gate drivers of a synchronous half-bridge. It splits the single command into a high-side enable and a low-side enable. It guarantees that the two switches are never commanded on together. Dead time is set adaptively: each switch turns on only after sensing shows that the opposite gate has really turned off. A minimum interval, counted in clock cycles, is also enforced for each direction of transition.

For a turn-on of the high side, the low-side gate-sense flag must read off for a programmable number of consecutive cycles. For a turn-on of the low side, the high-side gate-sense flag must read off. In addition, the switch-node-low flag must have been present for a short programmable number of cycles. If that flag never arrives, a timeout counted from the high-side release lets the low side turn on anyway.

All sense flags come from analog comparators and pass through two-flop synchronisers. A fault input drops both enables in the same cycle and parks the sequencer in idle. A saturating status counter records every cycle in which both enables were high, so that a system check can confirm it stays at zero.

Top module: `nonoverlap_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle. `overlap_cnt` counts such cycles, saturating at its maximum, and reads zero in normal operation.
- R2: While `fault` is high, both enables are low in that same cycle, whatever `pwm_cmd` does. The sequencer returns to idle. After `fault` clears with `pwm_cmd` high, `hs_en` rises LH_GAP+2 cycles later.
- R3: The high side turns on only after the synchronised low-side sense has read off for LH_GAP consecutive cycles. Starting from steady low-side conduction with the gate model used by the bench (sense follows enable one cycle later), `hs_en` rises LH_GAP+5 clock edges after `pwm_cmd` rises.
- R4: With the high-side sense already off, `ls_en` rises SW_GAP+3 clock edges after `sw_node_low` rises. The flag must stay high through the SW_GAP count.
- R5: If `sw_node_low` never rises, `ls_en` rises SW_TIMEOUT+2 clock edges after `pwm_cmd` falls from high-side conduction.
- R6: No enable rises while the opposite gate's sense input reads on. This holds even past the timeout. Once a stuck sense releases, the waiting side proceeds. The low side rises 4 edges after the release. The high side rises LH_GAP+4 edges after the release.
- R7: While reset is high and after it is released, both enables and `overlap_cnt` are zero. The sequencer stays idle, with both enables low, for as long as `pwm_cmd` stays low. The first `pwm_cmd` high turns on the high side LH_GAP+2 edges later.
- R8: `hs_gate_on`, `ls_gate_on` and `sw_node_low` each pass through a two-flop synchroniser before use. This adds two cycles to every sense-driven latency listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 1 | PWM command, 1 requests high-side conduction |
| fault | input | 1 | Fault flag, forces both enables low |
| hs_gate_on | input | 1 | High-side gate sensed on (asynchronous) |
| ls_gate_on | input | 1 | Low-side gate sensed on (asynchronous) |
| sw_node_low | input | 1 | Switch node sensed low (asynchronous) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| overlap_cnt | output | OVC_W | Saturating count of cycles with both enables high |

## Verification
The checker watches the following on every cycle:
- the two enables are mutually exclusive;
- a fault silences both enables;
- each enable rises only after the opposite enable has been low for at least its minimum interval;
- each enable rises only once the opposite sense flag had read off at the synchroniser input.

The directed scenarios are needed for properties the checker does not cover:
- exact turn-on latencies through the synchronisers;
- the switch-node fallback timeout;
- holding off indefinitely behind a stuck sense flag;
- idle behaviour after reset and after a fault clears.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_HS_GAP,
        SEQ_HS_ON,
        SEQ_LS_WAIT,
        SEQ_LS_ON
    } seq_state_t;

    typedef struct packed {
        logic hs_on;
        logic ls_on;
        logic sw_low;
    } sense_t;

    localparam int SENSE_W = 3;

    function automatic int cnt_bits(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[0], d[i]};
            end
            assign q[i] = pipe[1];
        end
    endgenerate
endmodule

// File: rtl/gs_timer.sv
module gs_timer
    import gate_seq_pkg::*;
#(
    parameter int TARGET = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int CW = cnt_bits(TARGET);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(TARGET));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
    import gate_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwm,
    input  logic   fault,
    input  sense_t sn,
    input  logic   gap_done,
    input  logic   sw_done,
    input  logic   tmo_done,
    output logic   gap_clr,
    output logic   sw_clr,
    output logic   tmo_clr,
    output logic   hs_req,
    output logic   ls_req
);
    seq_state_t st, nxt;

    always_comb begin
        nxt = st;
        if (fault) begin
            nxt = SEQ_IDLE;
        end else begin
            case (st)
                SEQ_IDLE:    if (pwm) nxt = SEQ_HS_GAP;
                SEQ_HS_GAP:  if (!pwm) nxt = SEQ_LS_WAIT;
                             else if (gap_done && !sn.ls_on) nxt = SEQ_HS_ON;
                SEQ_HS_ON:   if (!pwm) nxt = SEQ_LS_WAIT;
                SEQ_LS_WAIT: if (pwm) nxt = SEQ_HS_GAP;
                             else if (!sn.hs_on && (sw_done || tmo_done)) nxt = SEQ_LS_ON;
                SEQ_LS_ON:   if (pwm) nxt = SEQ_HS_GAP;
                default:     nxt = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SEQ_IDLE;
        else     st <= nxt;
    end

    assign gap_clr = (st != SEQ_HS_GAP) || sn.ls_on;
    assign sw_clr  = (st != SEQ_LS_WAIT) || !sn.sw_low;
    assign tmo_clr = (st != SEQ_LS_WAIT);
    assign hs_req  = (st == SEQ_HS_ON);
    assign ls_req  = (st == SEQ_LS_ON);
endmodule

// File: rtl/nonoverlap_gate_seq.sv
module nonoverlap_gate_seq
    import gate_seq_pkg::*;
#(
    parameter int LH_GAP     = 5,
    parameter int SW_GAP     = 2,
    parameter int SW_TIMEOUT = 16,
    parameter int OVC_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_cmd,
    input  logic             fault,
    input  logic             hs_gate_on,
    input  logic             ls_gate_on,
    input  logic             sw_node_low,
    output logic             hs_en,
    output logic             ls_en,
    output logic [OVC_W-1:0] overlap_cnt
);
    sense_t raw_s, syn_s;
    logic   gap_clr, sw_clr, tmo_clr;
    logic   gap_done, sw_done, tmo_done;
    logic   hs_req, ls_req;

    assign raw_s = '{hs_on: hs_gate_on, ls_on: ls_gate_on, sw_low: sw_node_low};

    gs_sync #(.W(SENSE_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (syn_s)
    );

    gs_timer #(.TARGET(LH_GAP)) u_gap_tmr (
        .clk (clk), .rst (rst), .clr (gap_clr), .done (gap_done)
    );

    gs_timer #(.TARGET(SW_GAP)) u_sw_tmr (
        .clk (clk), .rst (rst), .clr (sw_clr), .done (sw_done)
    );

    gs_timer #(.TARGET(SW_TIMEOUT)) u_tmo_tmr (
        .clk (clk), .rst (rst), .clr (tmo_clr), .done (tmo_done)
    );

    gs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwm      (pwm_cmd),
        .fault    (fault),
        .sn       (syn_s),
        .gap_done (gap_done),
        .sw_done  (sw_done),
        .tmo_done (tmo_done),
        .gap_clr  (gap_clr),
        .sw_clr   (sw_clr),
        .tmo_clr  (tmo_clr),
        .hs_req   (hs_req),
        .ls_req   (ls_req)
    );

    assign hs_en = hs_req && !fault;
    assign ls_en = ls_req && !fault;

    always_ff @(posedge clk) begin
        if (rst)
            overlap_cnt <= '0;
        else if (hs_en && ls_en && (overlap_cnt != '1))
            overlap_cnt <= overlap_cnt + 1'b1;
    end
endmodule

// File: rtl/gate_seq_checker.sv
module gate_seq_checker
    import gate_seq_pkg::*;
#(
    parameter int LH_GAP = 5,
    parameter int SW_GAP = 2
) (
    input logic clk,
    input logic rst,
    input logic fault,
    input logic hs_gate_on,
    input logic ls_gate_on,
    input logic hs_en,
    input logic ls_en
);
    localparam int LIM = LH_GAP + SW_GAP + 4;
    localparam int CW  = cnt_bits(LIM);

    logic [CW-1:0] ls_off_cnt, hs_off_cnt;

    always_ff @(posedge clk) begin
        if (rst || ls_en)            ls_off_cnt <= '0;
        else if (ls_off_cnt != CW'(LIM)) ls_off_cnt <= ls_off_cnt + 1'b1;
        if (rst || hs_en)            hs_off_cnt <= '0;
        else if (hs_off_cnt != CW'(LIM)) hs_off_cnt <= hs_off_cnt + 1'b1;
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_fault_off_R2: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!hs_en && !ls_en));

    assert_hs_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> (ls_off_cnt >= CW'(LH_GAP)));

    assert_ls_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> (hs_off_cnt >= CW'(SW_GAP)));

    assert_ls_sense_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(!hs_gate_on, 3));

    assert_hs_sense_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(!ls_gate_on, 3));
endmodule

bind nonoverlap_gate_seq gate_seq_checker #(
    .LH_GAP (LH_GAP),
    .SW_GAP (SW_GAP)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .fault      (fault),
    .hs_gate_on (hs_gate_on),
    .ls_gate_on (ls_gate_on),
    .hs_en      (hs_en),
    .ls_en      (ls_en)
);

// File: tb/nonoverlap_gate_seq_bench.sv
module nonoverlap_gate_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LH  = 5;
    localparam int SW  = 2;
    localparam int TMO = 16;
    localparam int OVW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_cmd = 1'b0;
    logic fault = 1'b0;
    logic hs_gate_on = 1'b0;
    logic ls_gate_on = 1'b0;
    logic sw_node_low = 1'b0;
    logic stuck_hs = 1'b0;
    logic stuck_ls = 1'b0;
    logic hs_en, ls_en;
    logic [OVW-1:0] overlap_cnt;

    int checks = 0;
    int bad = 0;
    int both_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nonoverlap_gate_seq #(
        .LH_GAP (LH), .SW_GAP (SW), .SW_TIMEOUT (TMO), .OVC_W (OVW)
    ) u_nonoverlap_gate_seq (
        .clk (clk), .rst (rst), .pwm_cmd (pwm_cmd), .fault (fault),
        .hs_gate_on (hs_gate_on), .ls_gate_on (ls_gate_on),
        .sw_node_low (sw_node_low), .hs_en (hs_en), .ls_en (ls_en),
        .overlap_cnt (overlap_cnt)
    );

    // gate model: sensed state follows the enable one cycle later
    always @(posedge clk) begin
        hs_gate_on <= stuck_hs | hs_en;
        ls_gate_on <= stuck_ls | ls_en;
    end

    always @(negedge clk) if (hs_en && ls_en) both_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic edges_to_rise(input bit hs_side, output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while ((hs_side ? !hs_en : !ls_en) && n < 200);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        check("R7 hs_en in reset", hs_en, 0);
        check("R7 ls_en in reset", ls_en, 0);
        rst = 1'b0;
        step(30);
        check("R7 idle hs_en", hs_en, 0);
        check("R7 idle ls_en", ls_en, 0);
        check("R7 overlap_cnt", overlap_cnt, 0);
    endtask

    task automatic t_first_start();
        int n;
        pwm_cmd = 1'b1;
        edges_to_rise(1'b1, n);
        check("R7 first high-side latency", n, LH + 2);
        step(4);
    endtask

    task automatic t_sw_handoff();
        int n;
        pwm_cmd = 1'b0;
        step(4);
        check("R4 ls_en before sw flag", ls_en, 0);
        sw_node_low = 1'b1;
        edges_to_rise(1'b0, n);
        check("R4 R8 switch-node to low-side latency", n, SW + 3);
        step(4);
    endtask

    task automatic t_ls_to_hs();
        int n;
        pwm_cmd = 1'b1;
        edges_to_rise(1'b1, n);
        sw_node_low = 1'b0;
        check("R3 R8 low-to-high latency", n, LH + 5);
        step(4);
    endtask

    task automatic t_timeout();
        int n;
        pwm_cmd = 1'b0;
        edges_to_rise(1'b0, n);
        check("R5 timeout latency", n, TMO + 2);
        step(4);
    endtask

    task automatic t_hs_stuck();
        int n;
        pwm_cmd = 1'b1;
        edges_to_rise(1'b1, n);
        check("R3 high side after timeout", n, LH + 5);
        step(4);
        stuck_hs = 1'b1;
        pwm_cmd = 1'b0;
        step(3 * TMO);
        check("R6 ls_en held by stuck high-side sense", ls_en, 0);
        stuck_hs = 1'b0;
        edges_to_rise(1'b0, n);
        check("R6 low side after sense release", n, 4);
        step(4);
    endtask

    task automatic t_ls_stuck();
        int n;
        stuck_ls = 1'b1;
        pwm_cmd = 1'b1;
        step(40);
        check("R6 hs_en held by stuck low-side sense", hs_en, 0);
        stuck_ls = 1'b0;
        edges_to_rise(1'b1, n);
        check("R6 high side after sense release", n, LH + 4);
        step(4);
    endtask

    task automatic t_fault();
        int n;
        fault = 1'b1;
        #1;
        check("R2 hs_en drops with fault", hs_en, 0);
        for (int i = 0; i < 6; i++) begin
            pwm_cmd = i[0];
            step(3);
            check("R2 hs_en under fault", hs_en, 0);
            check("R2 ls_en under fault", ls_en, 0);
        end
        pwm_cmd = 1'b1;
        step(4);
        fault = 1'b0;
        edges_to_rise(1'b1, n);
        check("R2 restart latency", n, LH + 2);
        step(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_first_start();
        t_sw_handoff();
        t_ls_to_hs();
        t_timeout();
        t_hs_stuck();
        t_ls_stuck();
        t_fault();
        check("R1 overlap_cnt", overlap_cnt, 0);
        check("R1 both enables seen", both_seen, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule